// File: doc/BRIEF.md
# Minimal 16-bit Instruction Core

This block is a single-thread execution core for a compact 16-bit instruction set. It keeps its own program counter and presents it on an address port to a synchronous program ROM. One cycle later it reads back the instruction word and executes it. It has eight 8-bit general registers and a three-flag condition set (negative, zero, positive). It supports register and immediate adds, immediate moves, an unsigned compare, and a branch that is taken only when the negative flag is set. A return instruction halts the core, which then holds `done` high.

Two opcodes drive an external functional unit. The first hands a register value to the unit's operand input for one cycle. The second fires the unit and writes the unit's result into a register. The load opcode is a placeholder that only advances the program counter.

Top module: `mini_core`

## Requirements
- R1: Instruction fields are opcode [15:12], rd [11:9], rs [8:6] and a 6-bit field [5:0]. Opcode 0001 writes rs + rt to rd, where rt is indexed by bits [2:0] and bits [5:3] are ignored.
- R2: Opcode 0101 writes rs plus the 6-bit field, zero-extended to 8 bits, into rd. All additions wrap modulo 256.
- R3: Opcode 0010 writes the zero-extended 6-bit field into rd.
- R4: Opcode 0011 compares rs with rt as unsigned numbers. It sets exactly one flag: N if rs < rt, Z if they are equal, P if rs > rt. No other opcode changes the flags.
- R5: Opcode 1000 loads the program counter with bits [7:0] when N is set. Otherwise the program counter advances by one.
- R6: Opcode 1111 halts the core. From then on `done` stays 1, `rom_addr` is frozen, and neither functional-unit strobe is asserted.
- R7: Opcode 0100 and every opcode not listed here change no register and no flag. They only advance the program counter.
- R8: Opcode 0110 asserts `fu_push` for exactly one cycle, with the value of rs on `fu_operand`.
- R9: Opcode 0111 asserts `fu_fire` for one cycle and writes `fu_result`, sampled in that cycle, into rd.
- R10: While reset is active and after it is released, the program counter is 0, the flags are Z, all registers are 0 and `done` is 0.
- R11: Each instruction takes two cycles. The address is presented in one cycle and the word is executed in the next, so a program of k executed instructions raises `done` after 2k clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rom_addr | output | 8 | Program ROM address (the program counter) |
| rom_data | input | 16 | Instruction word, valid one cycle after the address |
| fu_push | output | 1 | Operand push strobe to the functional unit |
| fu_operand | output | 8 | Operand value (the rs register) |
| fu_fire | output | 1 | Fire strobe to the functional unit |
| fu_result | input | 8 | Functional-unit result, written to rd on fire |
| done | output | 1 | High once the core has halted |

## Verification
The registers and flags have no port of their own, so their contents are hard to see from outside. The bench therefore places push instructions at chosen points in each program, which brings register values out on `fu_operand`. A scoreboard compares each pushed value in order.

Flag state is seen only through the branch. The programs are built so that a wrong flag makes the core skip a push, or make one it should not. That shows up as a missing or extra scoreboard item. One program is timed to the exact halt cycle, which also confirms how many times its loop ran.

// File: rtl/mcore_pkg.sv
package mcore_pkg;
  localparam int unsigned INSTR_W = 16;
  localparam int unsigned RIDX_W  = 3;
  localparam int unsigned FIELD_W = 6;

  typedef enum logic [3:0] {
    OP_ADDR = 4'b0001,
    OP_MOVI = 4'b0010,
    OP_CMP  = 4'b0011,
    OP_LOAD = 4'b0100,
    OP_ADDI = 4'b0101,
    OP_PUSH = 4'b0110,
    OP_FIRE = 4'b0111,
    OP_BRN  = 4'b1000,
    OP_RET  = 4'b1111
  } opcode_e;

  typedef enum logic { ALU_SUM, ALU_PASS } alu_sel_e;

  typedef enum logic [1:0] { ST_FETCH, ST_EXEC, ST_HALT } state_e;

  typedef struct packed {
    logic     wr_en;
    logic     wr_fu;
    logic     use_imm;
    alu_sel_e alu_sel;
    logic     is_cmp;
    logic     is_brn;
    logic     is_ret;
    logic     is_push;
    logic     is_fire;
  } ctrl_t;

  typedef struct packed {
    logic n;
    logic z;
    logic p;
  } flags_t;
endpackage

// File: rtl/mcore_decode.sv
module mcore_decode
  import mcore_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output ctrl_t              ctrl,
  output logic [RIDX_W-1:0]  rd,
  output logic [RIDX_W-1:0]  rs,
  output logic [RIDX_W-1:0]  rt,
  output logic [FIELD_W-1:0] field
);
  assign rd    = instr[11:9];
  assign rs    = instr[8:6];
  assign rt    = instr[2:0];
  assign field = instr[5:0];

  always_comb begin
    ctrl = '0;
    case (opcode_e'(instr[15:12]))
      OP_ADDR: ctrl.wr_en = 1'b1;
      OP_ADDI: begin
        ctrl.wr_en   = 1'b1;
        ctrl.use_imm = 1'b1;
      end
      OP_MOVI: begin
        ctrl.wr_en   = 1'b1;
        ctrl.use_imm = 1'b1;
        ctrl.alu_sel = ALU_PASS;
      end
      OP_CMP:  ctrl.is_cmp  = 1'b1;
      OP_BRN:  ctrl.is_brn  = 1'b1;
      OP_RET:  ctrl.is_ret  = 1'b1;
      OP_PUSH: ctrl.is_push = 1'b1;
      OP_FIRE: begin
        ctrl.is_fire = 1'b1;
        ctrl.wr_en   = 1'b1;
        ctrl.wr_fu   = 1'b1;
      end
      default: ctrl = '0;
    endcase
  end
endmodule

// File: rtl/mcore_regfile.sv
module mcore_regfile #(
  parameter int unsigned NREG   = 8,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned AW    = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [AW-1:0]     raddr_b,
  output logic [DATA_W-1:0] rdata_b
);
  logic [DATA_W-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                          regs[g] <= '0;
      else if (we && waddr == AW'(g))      regs[g] <= wdata;
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];
endmodule

// File: rtl/mcore_alu.sv
module mcore_alu
  import mcore_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  alu_sel_e          sel,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y,
  output flags_t            cmp_flags
);
  function automatic logic [DATA_W-1:0] wrap_add(input logic [DATA_W-1:0] x,
                                                 input logic [DATA_W-1:0] z);
    return x + z;
  endfunction

  function automatic flags_t order_of(input logic [DATA_W-1:0] x,
                                      input logic [DATA_W-1:0] z);
    flags_t f;
    f.n = (x < z);
    f.z = (x == z);
    f.p = (x > z);
    return f;
  endfunction

  assign y         = (sel == ALU_PASS) ? b : wrap_add(a, b);
  assign cmp_flags = order_of(a, b);
endmodule

// File: rtl/mini_core.sv
module mini_core
  import mcore_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PC_W   = 8,
  parameter int unsigned NREG   = 8,
  localparam int unsigned REG_AW = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [PC_W-1:0]    rom_addr,
  input  logic [INSTR_W-1:0] rom_data,
  output logic               fu_push,
  output logic [DATA_W-1:0]  fu_operand,
  output logic               fu_fire,
  input  logic [DATA_W-1:0]  fu_result,
  output logic               done
);
  state_e             state;
  logic [PC_W-1:0]    pc;
  flags_t             flags;

  ctrl_t              ctrl;
  logic [RIDX_W-1:0]  rd, rs, rt;
  logic [FIELD_W-1:0] field;
  logic [DATA_W-1:0]  rs_val, rt_val, b_opnd, alu_y, wdata;
  flags_t             cmp_flags;

  logic               exec_cyc;
  logic               br_taken;
  logic               halt_now;
  logic [PC_W-1:0]    br_target;

  mcore_decode u_dec (
    .instr (rom_data),
    .ctrl  (ctrl),
    .rd    (rd),
    .rs    (rs),
    .rt    (rt),
    .field (field)
  );

  mcore_regfile #(.NREG(NREG), .DATA_W(DATA_W)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (exec_cyc && ctrl.wr_en),
    .waddr   (REG_AW'(rd)),
    .wdata   (wdata),
    .raddr_a (REG_AW'(rs)),
    .rdata_a (rs_val),
    .raddr_b (REG_AW'(rt)),
    .rdata_b (rt_val)
  );

  mcore_alu #(.DATA_W(DATA_W)) u_alu (
    .sel       (ctrl.alu_sel),
    .a         (rs_val),
    .b         (b_opnd),
    .y         (alu_y),
    .cmp_flags (cmp_flags)
  );

  assign b_opnd    = ctrl.use_imm ? DATA_W'(field) : rt_val;
  assign wdata     = ctrl.wr_fu ? fu_result : alu_y;

  assign exec_cyc  = (state == ST_EXEC);
  assign br_target = rom_data[PC_W-1:0];
  assign br_taken  = exec_cyc && ctrl.is_brn && flags.n;
  assign halt_now  = exec_cyc && ctrl.is_ret;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_FETCH;
      pc    <= '0;
      flags <= '{n: 1'b0, z: 1'b1, p: 1'b0};
    end else begin
      case (state)
        ST_FETCH: state <= ST_EXEC;
        ST_EXEC: begin
          if (ctrl.is_ret) begin
            state <= ST_HALT;
          end else begin
            state <= ST_FETCH;
            pc    <= br_taken ? br_target : pc + PC_W'(1);
          end
          if (ctrl.is_cmp) flags <= cmp_flags;
        end
        default: state <= ST_HALT;
      endcase
    end
  end

  assign rom_addr   = pc;
  assign fu_push    = exec_cyc && ctrl.is_push;
  assign fu_fire    = exec_cyc && ctrl.is_fire;
  assign fu_operand = rs_val;
  assign done       = (state == ST_HALT);
endmodule

// File: rtl/mcore_chk.sv
module mcore_chk #(
  parameter int unsigned PC_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            done,
  input logic [PC_W-1:0] rom_addr,
  input logic            fu_push,
  input logic            fu_fire,
  input logic            exec_cyc,
  input logic            br_taken,
  input logic            halt_now,
  input logic [2:0]      flag_bits,
  input logic [PC_W-1:0] br_target
);
  // R6
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  // R6
  halt_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> $stable(rom_addr));

  // R6
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!fu_push && !fu_fire));

  // R4
  flag_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(flag_bits) == 1);

  // R5
  branch_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |=> rom_addr == $past(br_target));

  // R11
  step_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_cyc && !br_taken && !halt_now) |=> rom_addr == PC_W'($past(rom_addr) + 1'b1));

  // R11
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!exec_cyc && !done) |=> $stable(rom_addr));

  // R8
  push_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fu_push |=> !fu_push);

  // R9
  fire_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fu_fire |=> !fu_fire);
endmodule

bind mini_core mcore_chk #(.PC_W(PC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .done      (done),
  .rom_addr  (rom_addr),
  .fu_push   (fu_push),
  .fu_fire   (fu_fire),
  .exec_cyc  (exec_cyc),
  .br_taken  (br_taken),
  .halt_now  (halt_now),
  .flag_bits (flags),
  .br_target (br_target)
);

// File: tb/test_mini_core.sv
`timescale 1ns/1ps
module test_mini_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  rom_addr;
  logic [15:0] rom_data;
  logic        fu_push, fu_fire, done;
  logic [7:0]  fu_operand;
  logic [7:0]  fu_result = 8'h9C;

  int checks = 0;
  int errors = 0;
  int fire_cnt = 0;

  logic [15:0] rom [256];
  logic [7:0]  exp_q [$];
  string       tag_q [$];

  always #2.5 clk = ~clk;

  always_ff @(posedge clk) rom_data <= rom[rom_addr];

  mini_core i_mini_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .rom_addr   (rom_addr),
    .rom_data   (rom_data),
    .fu_push    (fu_push),
    .fu_operand (fu_operand),
    .fu_fire    (fu_fire),
    .fu_result  (fu_result),
    .done       (done)
  );

  function automatic logic [15:0] enc(input logic [3:0] op, input logic [2:0] d,
                                      input logic [2:0] s, input logic [5:0] f);
    return {op, d, s, f};
  endfunction

  function automatic logic [15:0] brn(input logic [7:0] t);
    return {8'h80, t};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic expect_push(input logic [7:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  // Scoreboard monitor: compares every pushed operand against the queue
  always @(negedge clk) begin
    if (rst_n && fu_push) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R8 unexpected push actual %0h expected none", fu_operand);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (fu_operand !== e) begin
          errors++;
          $display("FAIL %s push actual %0h expected %0h", t, fu_operand, e);
        end
      end
    end
    if (rst_n && fu_fire) fire_cnt++;
  end

  task automatic start_program();
    rst_n = 1'b0;
    fire_cnt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state at the ports
    chk(rom_addr == 8'd0, "R10 rom_addr in reset", rom_addr, 0);
    chk(!done && !fu_push && !fu_fire, "R10 outputs idle in reset",
        {done, fu_push, fu_fire}, 0);
    rst_n = 1'b1;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done && n < 1000) begin
      @(negedge clk);
      n++;
    end
    chk(done, tag, done, 1);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // ---------------- Program A ----------------
    for (int i = 0; i < 256; i++) rom[i] = 16'hF000;
    rom[0]  = brn(8'd3);                    // R10/R5 flags reset to Z: not taken
    rom[1]  = enc(4'h6, 0, 6, 0);           // push R6 -> 0 (R10)
    rom[2]  = enc(4'h2, 1, 0, 6'd63);       // R3 MOV R1,#63
    rom[3]  = enc(4'h1, 1, 1, 6'd1);        // R1 R1=126
    rom[4]  = enc(4'h1, 1, 1, 6'd1);        // R1 R1=252
    rom[5]  = enc(4'h5, 1, 1, 6'd10);       // R2 R1=262 mod 256 = 6
    rom[6]  = enc(4'h6, 0, 1, 0);           // push 6
    rom[7]  = enc(4'h1, 2, 1, 6'b111001);   // R1 rt from [2:0] -> R2 = 12
    rom[8]  = enc(4'h6, 0, 2, 0);           // push 12
    rom[9]  = enc(4'h4, 1, 2, 6'd63);       // R7 load stub
    rom[10] = enc(4'h9, 1, 2, 6'd5);        // R7 undefined opcode
    rom[11] = enc(4'h6, 0, 1, 0);           // push R1 still 6
    rom[12] = enc(4'h7, 5, 0, 0);           // R9 fire -> R5 = 9C
    rom[13] = enc(4'h6, 0, 5, 0);           // push 9C
    rom[14] = enc(4'h3, 0, 1, 6'd1);        // R4 CMP R1,R1 -> Z
    rom[15] = brn(8'd17);                   // not taken
    rom[16] = enc(4'h6, 0, 1, 0);           // push 6
    rom[17] = enc(4'h3, 0, 0, 6'd1);        // R4 CMP R0,R1 -> N
    rom[18] = enc(4'h1, 3, 0, 6'd0);        // R4 add giving zero, flags keep N
    rom[19] = brn(8'd22);                   // R5 taken
    rom[20] = enc(4'h6, 0, 1, 0);           // skipped
    rom[21] = enc(4'h6, 0, 2, 0);           // skipped
    rom[22] = enc(4'h6, 0, 2, 0);           // push 12
    rom[23] = enc(4'h3, 0, 1, 6'd0);        // CMP R1,R0 -> P
    rom[24] = brn(8'd27);                   // not taken
    rom[25] = enc(4'h6, 0, 3, 0);           // push R3 = 0
    rom[26] = 16'hF000;                     // R6 halt
    rom[27] = enc(4'h6, 0, 1, 0);           // never reached

    expect_push(8'h00, "R10 register reset value");
    expect_push(8'h06, "R2 wrap add");
    expect_push(8'h0C, "R1 register operand");
    expect_push(8'h06, "R7 no-op opcodes");
    expect_push(8'h9C, "R9 fire writeback");
    expect_push(8'h06, "R5 branch not taken on Z");
    expect_push(8'h0C, "R5 branch taken on N");
    expect_push(8'h00, "R4 not taken on P");

    start_program();
    wait_done("R6 program A halts");
    chk(exp_q.size() == 0, "R8 all pushes seen", exp_q.size(), 0);
    chk(fire_cnt == 1, "R9 one fire strobe", fire_cnt, 1);
    begin
      automatic logic [7:0] a0 = rom_addr;
      repeat (6) @(negedge clk);
      chk(done && rom_addr == a0, "R6 halted state frozen", rom_addr, a0);
    end
    exp_q.delete();
    tag_q.delete();

    // ---------------- Program B ----------------
    for (int i = 0; i < 256; i++) rom[i] = 16'hF000;
    rom[0]  = enc(4'h2, 1, 0, 6'd5);
    rom[1]  = enc(4'h2, 2, 0, 6'd3);
    rom[2]  = enc(4'h2, 3, 0, 6'd0);
    rom[3]  = enc(4'h2, 4, 0, 6'd0);
    rom[4]  = enc(4'h1, 3, 3, 6'd1);        // R3 += R1
    rom[5]  = enc(4'h5, 4, 4, 6'd1);        // R4 += 1
    rom[6]  = enc(4'h3, 0, 4, 6'd2);        // CMP R4,R2
    rom[7]  = brn(8'd4);
    rom[8]  = enc(4'h6, 0, 3, 0);           // push 15
    rom[9]  = enc(4'h2, 7, 0, 6'd63);       // R3 MOV 63
    rom[10] = enc(4'h5, 7, 7, 6'd63);       // R2 zero-extended imm -> 126
    rom[11] = enc(4'h1, 7, 7, 6'd7);        // 252
    rom[12] = enc(4'h3, 0, 7, 6'd1);        // R4 unsigned 252 > 5 -> P
    rom[13] = brn(8'd15);                   // not taken
    rom[14] = enc(4'h6, 0, 7, 0);           // push FC
    rom[15] = 16'hF000;

    expect_push(8'h0F, "R5 loop result");
    expect_push(8'hFC, "R4 unsigned compare");

    start_program();
    // 24 executed instructions: done rises after edge 48 (R11)
    repeat (47) @(posedge clk);
    @(negedge clk);
    chk(!done, "R11 done not before edge 48", done, 0);
    @(posedge clk);
    @(negedge clk);
    chk(done, "R11 done after edge 48", done, 1);
    chk(exp_q.size() == 0, "R4 all pushes seen", exp_q.size(), 0);
    chk(fire_cnt == 0, "R9 no fire strobe", fire_cnt, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule